// File: doc/BRIEF.md
# Masked Data Address Watchpoint Unit

This block watches the data accesses of a processor pipeline against a small set of watchpoint channels. Each channel has a watch address and a control word. The control word holds two qualifier bits that select stores, loads, or both. It also holds a low-order mask field that sets the size of a naturally aligned, power-of-two address window around the watch address.

The comparison is purely combinational against registered channel state. The pipeline therefore sees the per-channel hit vector and a stop-before-access request in the same cycle as it presents the access, and can cancel the access before it is performed. A mask field whose ones are not contiguous from the top is repaired by keeping only the leading run of ones.

The block also holds the enable word for the instruction breakpoints, trimmed to the number of instruction breakpoints that are implemented. Raising the debug exception after a hit is left to the surrounding logic.

Top module: `dbrk_unit`

## Requirements
- R1: After reset every channel is disabled and its watch address is zero: no access raises a hit or a stop request, and the instruction breakpoint enable output is zero.
- R2: In a control word, bit 31 makes a channel watch stores and bit 30 makes it watch loads. A channel with both bits clear never hits. An access flagged both load and store hits if either qualifier matches.
- R3: The raw mask of a channel is control bits 5:0, with all bits 31:6 forced to one. A channel hits when (access address AND mask) equals (watch address AND mask).
- R4: When the inverted raw mask is not one less than a power of two, the mask used instead keeps the raw ones from bit 31 down to the first zero bit and clears that bit and every bit below it. The resulting window size is the inverted mask plus one.
- R5: Hits and the stop request are combinational in the access inputs and need acc_valid high. stop_req is the OR of the hit vector.
- R6: A register write selects a channel with cfg_sel and updates that channel's register at the clock edge. The access comparison in the following cycle uses the new value, and the access comparison in the same cycle still uses the old value.
- R7: Writing the instruction breakpoint enable keeps only the low NUM_IBRK bits of the write data. With the default of 2, a write of 0xFFFFFFFF reads back 3.
- R8: Channels are independent. Hit bit i reflects only channel i, and a write to one channel leaves the other channel's matching unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel | input | SEL_W | Channel targeted by an address or control write |
| cfg_addr_we | input | 1 | Write cfg_wdata into the selected watch address |
| cfg_ctl_we | input | 1 | Write cfg_wdata into the selected control word |
| cfg_ibrk_we | input | 1 | Write the instruction breakpoint enable word |
| cfg_wdata | input | ADDR_W | Write data |
| acc_valid | input | 1 | A data access is presented this cycle |
| acc_load | input | 1 | The access reads |
| acc_store | input | 1 | The access writes |
| acc_addr | input | ADDR_W | Start address of the access |
| hit_vec | output | NUM_CH | Per-channel match |
| stop_req | output | 1 | Stop the access before it is performed |
| ibrk_enable | output | NUM_IBRK | Trimmed instruction breakpoint enables |

## Verification
The hardest cases to reach are non-contiguous mask fields. The repaired window depends on where the first zero falls, and that is visible only through which neighbouring addresses still hit. The bench therefore sweeps all 64 mask field values. For each value it flips every low address bit and the top bit, and it derives the expected window from a leading-ones count. A second hard case is a control write that coincides with an access. The bench holds the access across the edge, so it can show the old match before the edge and the new one after it.

// File: rtl/dbrk_pkg.sv
`timescale 1ns/1ps
package dbrk_pkg;

   // Qualifiers of one data access presented to the channels
   typedef struct packed {
      logic valid;
      logic is_load;
      logic is_store;
   } dbrk_acc_t;

   localparam int DBRK_DEF_ADDR_W = 32;
   localparam int DBRK_DEF_MASK_W = 6;

endpackage

// File: rtl/dbrk_mask_fix.sv
`timescale 1ns/1ps
// Builds the effective mask: the field with upper bits forced to one,
// reduced to its leading run of ones so the window is always aligned.
module dbrk_mask_fix #(
   parameter int ADDR_W = 32,
   parameter int MASK_W = 6
) (
   input  logic [MASK_W-1:0] fld,
   output logic [ADDR_W-1:0] mask
);

   logic [ADDR_W-1:0] raw;
   logic [ADDR_W-1:0] run;

   assign raw = {{(ADDR_W-MASK_W){1'b1}}, fld};

   // Prefix AND from the top: a bit survives only if all bits above are ones
   assign run[ADDR_W-1] = raw[ADDR_W-1];
   genvar gi;
   generate
      for (gi = ADDR_W-2; gi >= 0; gi--) begin : g_run
         assign run[gi] = run[gi+1] & raw[gi];
      end
   endgenerate

   assign mask = run;

endmodule

// File: rtl/dbrk_channel.sv
`timescale 1ns/1ps
module dbrk_channel
   import dbrk_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int MASK_W = 6,
   parameter int ST_BIT = 31,
   parameter int LD_BIT = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_addr,
   input  logic              wr_ctl,
   input  logic [ADDR_W-1:0] wr_data,
   input  dbrk_acc_t         acc,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              hit
);

   logic [ADDR_W-1:0] wp_addr;
   logic              st_en;
   logic              ld_en;
   logic [MASK_W-1:0] mask_fld;
   logic [ADDR_W-1:0] eff_mask;
   logic              kind_ok;
   logic              addr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_addr  <= '0;
         st_en    <= 1'b0;
         ld_en    <= 1'b0;
         mask_fld <= '0;
      end else begin
         if (wr_addr) wp_addr <= wr_data;
         if (wr_ctl) begin
            st_en    <= wr_data[ST_BIT];
            ld_en    <= wr_data[LD_BIT];
            mask_fld <= wr_data[MASK_W-1:0];
         end
      end
   end

   dbrk_mask_fix #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) i_mask (
      .fld  (mask_fld),
      .mask (eff_mask)
   );

   assign kind_ok = (st_en & acc.is_store) | (ld_en & acc.is_load);
   assign addr_ok = ((acc_addr ^ wp_addr) & eff_mask) == '0;
   assign hit     = acc.valid & kind_ok & addr_ok;

   AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_en && !ld_en) |-> !hit); // R2
   AST_MASK_UPPER_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      &eff_mask[ADDR_W-1:MASK_W]); // R3
   AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
      (((~eff_mask) + ADDR_W'(1)) & (~eff_mask)) == '0); // R4
   AST_NO_HIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !acc.valid |-> !hit); // R5
   AST_CTL_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl |=> (st_en == $past(wr_data[ST_BIT])) && (ld_en == $past(wr_data[LD_BIT]))); // R6

endmodule

// File: rtl/dbrk_ibrk_en.sv
`timescale 1ns/1ps
module dbrk_ibrk_en #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [N-1:0] wr_bits,
   output logic [N-1:0] en
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  en <= '0;
      else if (wr) en <= wr_bits;
   end

   AST_IBRK_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> en == $past(wr_bits)); // R7

endmodule

// File: rtl/dbrk_unit.sv
`timescale 1ns/1ps
module dbrk_unit
   import dbrk_pkg::*;
#(
   parameter int NUM_CH   = 2,
   parameter int ADDR_W   = DBRK_DEF_ADDR_W,
   parameter int MASK_W   = DBRK_DEF_MASK_W,
   parameter int ST_BIT   = 31,
   parameter int LD_BIT   = 30,
   parameter int NUM_IBRK = 2,
   localparam int SEL_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SEL_W-1:0]    cfg_sel,
   input  logic                cfg_addr_we,
   input  logic                cfg_ctl_we,
   input  logic                cfg_ibrk_we,
   input  logic [ADDR_W-1:0]   cfg_wdata,
   input  logic                acc_valid,
   input  logic                acc_load,
   input  logic                acc_store,
   input  logic [ADDR_W-1:0]   acc_addr,
   output logic [NUM_CH-1:0]   hit_vec,
   output logic                stop_req,
   output logic [NUM_IBRK-1:0] ibrk_enable
);

   // Elaboration-time parameter checks
   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("dbrk_unit: NUM_CH must be at least 1");
      end
      if (MASK_W < 1 || MASK_W >= ADDR_W) begin : g_bad_mask
         $error("dbrk_unit: MASK_W must lie in 1..ADDR_W-1");
      end
      if (ST_BIT == LD_BIT || ST_BIT < MASK_W || LD_BIT < MASK_W ||
          ST_BIT >= ADDR_W || LD_BIT >= ADDR_W) begin : g_bad_bits
         $error("dbrk_unit: qualifier bits must be distinct and above the mask field");
      end
      if (NUM_IBRK < 1 || NUM_IBRK > ADDR_W) begin : g_bad_ibrk
         $error("dbrk_unit: NUM_IBRK must lie in 1..ADDR_W");
      end
   endgenerate

   dbrk_acc_t acc;
   assign acc = '{valid: acc_valid, is_load: acc_load, is_store: acc_store};

   genvar gc;
   generate
      for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
         logic sel_me;
         assign sel_me = (cfg_sel == SEL_W'(gc));
         dbrk_channel #(
            .ADDR_W (ADDR_W),
            .MASK_W (MASK_W),
            .ST_BIT (ST_BIT),
            .LD_BIT (LD_BIT)
         ) i_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_addr  (cfg_addr_we & sel_me),
            .wr_ctl   (cfg_ctl_we & sel_me),
            .wr_data  (cfg_wdata),
            .acc      (acc),
            .acc_addr (acc_addr),
            .hit      (hit_vec[gc])
         );
      end
   endgenerate

   assign stop_req = |hit_vec;

   dbrk_ibrk_en #(.N(NUM_IBRK)) i_ibrk (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (cfg_ibrk_we),
      .wr_bits (cfg_wdata[NUM_IBRK-1:0]),
      .en      (ibrk_enable)
   );

   AST_STOP_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |-> acc_valid && (acc_load || acc_store)); // R5

endmodule

// File: tb/test_dbrk_unit.sv
`timescale 1ns/1ps
module test_dbrk_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [0:0]  cfg_sel = '0;
   logic        cfg_addr_we = 1'b0;
   logic        cfg_ctl_we = 1'b0;
   logic        cfg_ibrk_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        acc_valid = 1'b0;
   logic        acc_load = 1'b0;
   logic        acc_store = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  hit_vec;
   logic        stop_req;
   logic [1:0]  ibrk_enable;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk; // 200 MHz

   dbrk_unit i_dbrk_unit (
      .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel),
      .cfg_addr_we(cfg_addr_we), .cfg_ctl_we(cfg_ctl_we), .cfg_ibrk_we(cfg_ibrk_we),
      .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_load(acc_load),
      .acc_store(acc_store), .acc_addr(acc_addr), .hit_vec(hit_vec),
      .stop_req(stop_req), .ibrk_enable(ibrk_enable)
   );

   localparam logic [31:0] ST = 32'h8000_0000;
   localparam logic [31:0] LD = 32'h4000_0000;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // kind: 0 address, 1 control, 2 instruction enables
   task automatic wr(input int kind, input int sel, input logic [31:0] d);
      cfg_sel     = sel[0:0];
      cfg_wdata   = d;
      cfg_addr_we = (kind == 0);
      cfg_ctl_we  = (kind == 1);
      cfg_ibrk_we = (kind == 2);
      @(posedge clk); #1;
      cfg_addr_we = 1'b0; cfg_ctl_we = 1'b0; cfg_ibrk_we = 1'b0;
   endtask

   task automatic access(input logic v, input logic ld, input logic st, input logic [31:0] a);
      acc_valid = v; acc_load = ld; acc_store = st; acc_addr = a;
      #1;
   endtask

   // Expected window mask: leading ones of {ones, field}
   function automatic logic [31:0] exp_mask(input logic [5:0] f);
      logic [31:0] e;
      int k;
      bit run;
      e = {26'h3FF_FFFF, f};
      k = 0; run = 1'b1;
      for (int i = 31; i >= 0; i--) begin
         if (run && e[i]) k++;
         else run = 1'b0;
      end
      return ~(32'hFFFF_FFFF >> k);
   endfunction

   task automatic report;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         report();
      end
   end

   initial begin
      logic [31:0] base;
      logic [31:0] m;
      logic [31:0] a;
      logic        e;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1: reset state
      access(1'b1, 1'b1, 1'b1, 32'h0);
      chk("R1 hit after reset", {30'b0, hit_vec}, 32'h0);
      chk("R1 stop after reset", {31'b0, stop_req}, 32'h0);
      chk("R1 ibrk enable after reset", {30'b0, ibrk_enable}, 32'h0);

      // R3/R4: exhaustive mask field sweep on channel 0
      base = 32'h1234_5678;
      wr(0, 0, base);
      for (int f = 0; f < 64; f++) begin
         wr(1, 0, ST | LD | 32'(f));
         m = exp_mask(f[5:0]);
         for (int j = 0; j < 9; j++) begin
            a = (j == 8) ? (base ^ 32'h8000_0000) : (base ^ (32'h1 << j));
            e = ((a ^ base) & m) == 32'h0;
            access(1'b1, 1'b0, 1'b1, a);
            chk("R4 window match", {30'b0, hit_vec}, {31'b0, e});
         end
         access(1'b1, 1'b1, 1'b0, base);
         chk("R3 exact base hits", {30'b0, hit_vec}, 32'h1);
      end

      // R2: qualifier sweep on channel 1, exact mask, channel 0 off
      wr(1, 0, 32'h0);
      wr(0, 1, 32'hA000_0040);
      for (int q = 0; q < 4; q++) begin
         wr(1, 1, (q[1] ? ST : 32'h0) | (q[0] ? LD : 32'h0) | 32'h3F);
         for (int k = 0; k < 4; k++) begin
            e = (q[1] & k[1]) | (q[0] & k[0]);
            access(1'b1, k[0], k[1], 32'hA000_0040);
            chk("R2 qualifier", {30'b0, hit_vec}, {30'b0, e, 1'b0});
            chk("R5 stop is OR", {31'b0, stop_req}, {31'b0, e});
         end
      end

      // R8: independent channels
      wr(0, 0, 32'h0000_1000);
      wr(1, 0, ST | 32'h3C);          // 4-byte window, stores
      wr(0, 1, 32'h0000_2000);
      wr(1, 1, LD | 32'h30);          // 16-byte window, loads
      access(1'b1, 1'b0, 1'b1, 32'h0000_1003);
      chk("R8 ch0 store", {30'b0, hit_vec}, 32'h1);
      access(1'b1, 1'b1, 1'b0, 32'h0000_1003);
      chk("R8 ch0 ignores load", {30'b0, hit_vec}, 32'h0);
      access(1'b1, 1'b1, 1'b0, 32'h0000_200F);
      chk("R8 ch1 load", {30'b0, hit_vec}, 32'h2);
      access(1'b1, 1'b1, 1'b0, 32'h0000_2010);
      chk("R8 ch1 outside", {30'b0, hit_vec}, 32'h0);
      wr(0, 1, 32'h0000_1000);
      access(1'b1, 1'b0, 1'b1, 32'h0000_1000);
      chk("R8 ch0 unchanged by ch1 write", {30'b0, hit_vec}, 32'h1);
      access(1'b1, 1'b1, 1'b1, 32'h0000_1000);
      chk("R8 both channels", {30'b0, hit_vec}, 32'h3);

      // R5: valid low suppresses everything
      access(1'b0, 1'b1, 1'b1, 32'h0000_1000);
      chk("R5 no valid no hit", {30'b0, hit_vec}, 32'h0);
      chk("R5 no valid no stop", {31'b0, stop_req}, 32'h0);

      // R6: write coinciding with an access
      acc_valid = 1'b1; acc_load = 1'b0; acc_store = 1'b1; acc_addr = 32'h0000_1000;
      cfg_sel = 1'b0; cfg_wdata = 32'h0; cfg_ctl_we = 1'b1;
      #1;
      chk("R6 old value same cycle", {30'b0, hit_vec}, 32'h1);
      @(posedge clk); #1;
      cfg_ctl_we = 1'b0;
      chk("R6 new value next cycle", {30'b0, hit_vec}, 32'h0);

      // R7: instruction enable trimming
      wr(2, 0, 32'hFFFF_FFFF);
      chk("R7 trim all ones", {30'b0, ibrk_enable}, 32'h3);
      wr(2, 0, 32'h0000_0005);
      chk("R7 trim 5", {30'b0, ibrk_enable}, 32'h1);
      wr(2, 0, 32'h8000_0002);
      chk("R7 trim high bit", {30'b0, ibrk_enable}, 32'h2);

      done = 1'b1;
      report();
   end

endmodule